// File: doc/BRIEF.md
# Pixel Dual Counter Group with 2x2 Chaining

This block is the digital part of a group of four pixels arranged as a 2x2 cell. Every pixel takes a synchronous discriminator level and runs two counters at once while the shutter gate is open. Counter A measures time over threshold, which is the number of clock cycles with the discriminator high. Counter B measures either time of arrival or the number of hits, depending on the mode select. A counting-only mode moves hit counting onto counter A and parks counter B, which is used when pixel thresholds are being equalized. The fast time-reference clock is the block clock, so one count of time of arrival is one clock period.

The counters stop whenever the shutter is low, so their values can be shifted out between frames. A clear pulse zeroes them before the next shutter. A per-pixel hit flag shows that a pixel saw activity during the shutter, and a read pulse clears it. When the combine input is high, the four pixels appear as one large pixel. Its counters are four times as wide and are fed by the OR of the four discriminators. The wide value is spread over the four pixel fields of the same output buses, so the shift path does not change.

Top module: `pdc_superpixel`

## Requirements
- R1: While rst_n is low, and after reset, every counter field reads zero and every hit flag is low.
- R2: In modes 2'b00 and 2'b01, counter A goes up by one for each clock cycle in which the shutter and the pixel's discriminator are both high.
- R3: In mode 2'b00, counter B counts the shutter cycles from the pixel's first rising edge to the end of the shutter, counting the cycle of that edge. A rising edge is a cycle with the discriminator high after a cycle with it low. A level that is already high when the shutter opens starts nothing, and edges after the first have no effect.
- R4: In mode 2'b01, counter B goes up by one for each rising edge seen while the shutter is high.
- R5: In modes 2'b10 and 2'b11, counter A counts rising edges during the shutter and counter B stays at zero.
- R6: A pixel counter that reaches 2^CW-1 holds that value and does not wrap.
- R7: While the shutter is low, discriminator activity changes neither the counters nor the hit flags.
- R8: A clr_i cycle zeroes the counters, the hit flags and the time-of-arrival start, even when the shutter and the discriminator are high in the same cycle.
- R9: A discriminator high level during the shutter sets the pixel's hit flag. A rd_i cycle clears the flag unless activity happens in the same cycle, in which case the flag stays set.
- R10: When combine_i is high, each output bus carries one 4*CW-bit counter fed by the OR of the four discriminators, with pixel k holding bits [k*CW +: CW]. Every hit_o bit then shows the group flag. The pixel counters and the group counters run at the same time, so combine_i can be changed at any time and only selects which set is shown.
- R11: The combined counters saturate at 2^(4*CW)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast time-reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_i | input | 4 | Discriminator levels, one per pixel, synchronous to clk |
| shutter_i | input | 1 | Acquisition gate; counters move only while high |
| mode_i | input | 2 | 00 TOT+TOA, 01 TOT+hit count, 1x hit count only |
| combine_i | input | 1 | Show the chained 2x2 counters instead of per-pixel ones |
| clr_i | input | 1 | Synchronous clear of counters and flags |
| rd_i | input | 1 | Readout strobe; clears the hit flags |
| cnt_a_o | output | 4*CW | Counter A fields, pixel k at [k*CW +: CW] |
| cnt_b_o | output | 4*CW | Counter B fields, pixel k at [k*CW +: CW] |
| hit_o | output | 4 | Hit flag per pixel |

## Verification
The hardest state to reach from the ports is saturation of the chained group counter. It needs 2^(4*CW)-1 gated cycles, so the stimulus holds one discriminator high through a single shutter of more than 65,535 cycles. The same run also drives the pixel counter into its own saturation. The time-of-arrival start rules are the next hardest: a level already high at shutter open must not start the count, and a clear in the middle of a high level must not create a rising edge. Directed windows build exactly those sequences. A sweep over start offset, pulse width, pulse count and spacing covers each mode on every pixel, with the expected values worked out by arithmetic.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [1:0] {
        MODE_TOT_TOA = 2'b00,
        MODE_TOT_EVT = 2'b01,
        MODE_EVT_A   = 2'b10,
        MODE_EVT_B   = 2'b11
    } pdc_mode_e;
endpackage

// File: rtl/pdc_cell.sv
module pdc_cell
    import pdc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         disc_i,
    input  logic         shutter_i,
    input  pdc_mode_e    mode_i,
    input  logic         clr_i,
    input  logic         rd_i,
    output logic [W-1:0] cnt_a_o,
    output logic [W-1:0] cnt_b_o,
    output logic         hit_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         run;
        logic         hit;
        logic         prev;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic     rise;

    function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
        return (v == FULL) ? v : v + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        rise      = disc_i & ~st_q.prev;
        st_d.prev = disc_i;
        if (clr_i) begin
            st_d.a   = '0;
            st_d.b   = '0;
            st_d.run = 1'b0;
            st_d.hit = 1'b0;
        end else begin
            if (rd_i) st_d.hit = 1'b0;
            if (shutter_i) begin
                if (disc_i) st_d.hit = 1'b1;
                unique case (mode_i)
                    MODE_TOT_TOA: begin
                        if (disc_i) st_d.a = sat_inc(st_q.a);
                        st_d.run = st_q.run | rise;
                        if (st_q.run | rise) st_d.b = sat_inc(st_q.b);
                    end
                    MODE_TOT_EVT: begin
                        if (disc_i) st_d.a = sat_inc(st_q.a);
                        if (rise)   st_d.b = sat_inc(st_q.b);
                    end
                    default: begin
                        if (rise) st_d.a = sat_inc(st_q.a);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_a_o = st_q.a;
    assign cnt_b_o = st_q.b;
    assign hit_o   = st_q.hit;

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutter_i && !clr_i) |=> ($stable(cnt_a_o) && $stable(cnt_b_o)));
    assert_no_wrap_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a_o == FULL && !clr_i) |=> (cnt_a_o == FULL));
    assert_no_wrap_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_b_o == FULL && !clr_i) |=> (cnt_b_o == FULL));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_a_o == '0 && cnt_b_o == '0 && !hit_o));
    assert_b_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && cnt_b_o == '0) |=> (cnt_b_o == '0));
    assert_hit_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shutter_i && disc_i && !clr_i) |=> hit_o);
endmodule

// File: rtl/pdc_superpixel.sv
module pdc_superpixel
    import pdc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        disc_i,
    input  logic              shutter_i,
    input  logic [1:0]        mode_i,
    input  logic              combine_i,
    input  logic              clr_i,
    input  logic              rd_i,
    output logic [4*CW-1:0]   cnt_a_o,
    output logic [4*CW-1:0]   cnt_b_o,
    output logic [3:0]        hit_o
);
    localparam int NPIX = 4;
    localparam int GW   = NPIX * CW;

    pdc_mode_e         mode_e;
    logic [GW-1:0]     pix_a, pix_b;
    logic [NPIX-1:0]   pix_hit;
    logic [GW-1:0]     grp_a, grp_b;
    logic              grp_hit;

    assign mode_e = pdc_mode_e'(mode_i);

    for (genvar k = 0; k < NPIX; k++) begin : g_pix
        pdc_cell #(.W(CW)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .disc_i    (disc_i[k]),
            .shutter_i (shutter_i),
            .mode_i    (mode_e),
            .clr_i     (clr_i),
            .rd_i      (rd_i),
            .cnt_a_o   (pix_a[k*CW +: CW]),
            .cnt_b_o   (pix_b[k*CW +: CW]),
            .hit_o     (pix_hit[k])
        );
    end

    pdc_cell #(.W(GW)) u_group (
        .clk       (clk),
        .rst_n     (rst_n),
        .disc_i    (|disc_i),
        .shutter_i (shutter_i),
        .mode_i    (mode_e),
        .clr_i     (clr_i),
        .rd_i      (rd_i),
        .cnt_a_o   (grp_a),
        .cnt_b_o   (grp_b),
        .hit_o     (grp_hit)
    );

    always_comb begin
        if (combine_i) begin
            cnt_a_o = grp_a;
            cnt_b_o = grp_b;
            hit_o   = {NPIX{grp_hit}};
        end else begin
            cnt_a_o = pix_a;
            cnt_b_o = pix_b;
            hit_o   = pix_hit;
        end
    end

    assert_group_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|pix_hit) |-> grp_hit);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pix_a == '0 && grp_a == '0));
endmodule

// File: tb/test_pdc_superpixel.sv
`timescale 1ns/1ps
module test_pdc_superpixel;
    localparam int CW   = 4;
    localparam int NPIX = 4;
    localparam int PMAX = (1 << CW) - 1;
    localparam int S    = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIX-1:0]   disc = '0;
    logic              shutter = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              combine = 1'b0;
    logic              clr = 1'b0;
    logic              rd = 1'b0;
    logic [NPIX*CW-1:0] cnt_a, cnt_b;
    logic [NPIX-1:0]   hit;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    pdc_superpixel #(.CW(CW)) i_pdc_superpixel (
        .clk(clk), .rst_n(rst_n), .disc_i(disc), .shutter_i(shutter),
        .mode_i(mode), .combine_i(combine), .clr_i(clr), .rd_i(rd),
        .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .hit_o(hit)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clip(input int v);
        return (v > PMAX) ? PMAX : v;
    endfunction

    task automatic cyc(input logic [NPIX-1:0] d, input logic sh);
        disc = d;
        shutter = sh;
        @(negedge clk);
    endtask

    task automatic do_clr();
        clr = 1'b1;
        cyc('0, 1'b0);
        clr = 1'b0;
    endtask

    task automatic do_rd();
        rd = 1'b1;
        cyc('0, 1'b0);
        rd = 1'b0;
    endtask

    task automatic run_burst(input int k, input int md, input int st,
                             input int hl, input int np, input int per);
        int ea, eb;
        mode = md[1:0];
        do_clr();
        for (int c = 0; c < S; c++) begin
            logic on;
            on = (c >= st) && (((c - st) % per) < hl) && (((c - st) / per) < np);
            cyc(on ? (NPIX'(1) << k) : '0, 1'b1);
        end
        cyc('0, 1'b0);
        case (md)
            0: begin ea = np * hl; eb = S - st; end
            1: begin ea = np * hl; eb = np;     end
            default: begin ea = np; eb = 0;     end
        endcase
        combine = 1'b0;
        #1;
        for (int j = 0; j < NPIX; j++) begin
            chk((md == 2) ? "R5 pixel A" : "R2 pixel A",
                cnt_a[j*CW +: CW], (j == k) ? clip(ea) : 0);
            chk((md == 0) ? "R3 pixel B" : (md == 1) ? "R4 pixel B" : "R5 pixel B",
                cnt_b[j*CW +: CW], (j == k) ? clip(eb) : 0);
        end
        chk("R9 pixel hit", hit, NPIX'(1) << k);
        combine = 1'b1;
        #1;
        chk("R10 group A", cnt_a, ea);
        chk("R10 group B", cnt_b, eb);
        chk("R10 group hit", hit, {NPIX{1'b1}});
        combine = 1'b0;
        do_rd();
        chk("R9 hit cleared by rd", hit, 0);
    endtask

    initial begin
        #(150000 * 8);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 A in reset", cnt_a, 0);
        chk("R1 B in reset", cnt_b, 0);
        chk("R1 hit in reset", hit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 A after reset", cnt_a, 0);
        chk("R1 hit after reset", hit, 0);

        // sweep: every mode on every pixel over offsets, widths, counts, spacing
        begin
            int idx = 0;
            for (int md = 0; md < 3; md++)
                for (int st = 0; st < 4; st++)
                    for (int hl = 1; hl <= 3; hl++)
                        for (int np = 1; np <= 4; np++)
                            for (int g = 1; g <= 2; g++) begin
                                run_burst(idx % NPIX, md, st, hl, np, hl + g);
                                idx++;
                            end
        end

        // R3: level high at shutter open does not start TOA; later edge does
        for (int md = 0; md < 2; md++) begin
            mode = md[1:0];
            do_clr();
            cyc(4'b0001, 1'b0);
            for (int c = 0; c < 10; c++)
                cyc(((c < 3) || (c == 6) || (c == 7)) ? 4'b0001 : 4'b0000, 1'b1);
            cyc('0, 1'b0);
            chk("R2 A with preset level", cnt_a[CW-1:0], 5);
            chk(md == 0 ? "R3 TOA from first real edge" : "R4 one edge counted",
                cnt_b[CW-1:0], md == 0 ? 4 : 1);
        end

        // R7: activity with shutter low leaves everything untouched
        mode = 2'b01;
        do_clr();
        do_rd();
        for (int c = 0; c < 8; c++) cyc(c[0] ? 4'b1111 : 4'b0000, 1'b0);
        chk("R7 A frozen", cnt_a, 0);
        chk("R7 B frozen", cnt_b, 0);
        chk("R7 hit untouched", hit, 0);

        // R9: read in the same cycle as activity keeps the flag
        do_clr();
        cyc(4'b0100, 1'b1);
        chk("R9 hit set", hit[2], 1);
        rd = 1'b1;
        cyc(4'b0100, 1'b1);
        chk("R9 hit kept under activity", hit[2], 1);
        cyc(4'b0000, 1'b1);
        rd = 1'b0;
        chk("R9 hit cleared", hit[2], 0);
        cyc('0, 1'b0);

        // R8: clear wins over counting; no false edge afterwards
        mode = 2'b00;
        do_clr();
        cyc(4'b0001, 1'b1);
        cyc(4'b0001, 1'b1);
        clr = 1'b1;
        cyc(4'b0001, 1'b1);
        clr = 1'b0;
        chk("R8 A zeroed", cnt_a[CW-1:0], 0);
        chk("R8 B zeroed", cnt_b[CW-1:0], 0);
        chk("R8 hit zeroed", hit[0], 0);
        for (int c = 0; c < 3; c++) cyc(4'b0001, 1'b1);
        cyc('0, 1'b0);
        chk("R8 A after clear", cnt_a[CW-1:0], 3);
        chk("R8 TOA start cleared", cnt_b[CW-1:0], 0);

        // R10: overlapping pixels merge in the group
        mode = 2'b01;
        do_clr();
        for (int c = 0; c < 12; c++)
            cyc({2'b00, (c >= 4 && c <= 8), (c >= 2 && c <= 5)}, 1'b1);
        cyc('0, 1'b0);
        chk("R10 pixel0 A", cnt_a[0 +: CW], 4);
        chk("R10 pixel1 A", cnt_a[CW +: CW], 5);
        combine = 1'b1;
        #1;
        chk("R10 OR-merged A", cnt_a, 7);
        chk("R10 OR-merged edges", cnt_b, 1);
        combine = 1'b0;

        // R6, R11: long window drives both widths into saturation
        do_clr();
        cyc('0, 1'b1);
        for (int c = 0; c < 65545; c++) cyc(4'b0100, 1'b1);
        cyc('0, 1'b0);
        chk("R6 pixel A saturated", cnt_a[2*CW +: CW], PMAX);
        chk("R6 other pixel idle", cnt_a[0 +: CW], 0);
        combine = 1'b1;
        #1;
        chk("R11 group A saturated", cnt_a, 65535);
        chk("R11 group B one edge", cnt_b, 1);
        combine = 1'b0;

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule